// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the word-address stream for a multi-register load or store. A request carries a base address, a 16-bit mask that selects registers, a 2-bit walk mode and a writeback enable. Once the request is accepted, the sequencer emits one transfer per cycle. Each transfer carries a word address and the number of the register that moves at that address. It then pulses a completion flag and presents the base value that should be written back.

Four walk modes are offered: ascending from the base, ascending from the next word, descending ending at the base, and descending ending below the base. Whatever the direction, the lowest-numbered selected register always sits at the lowest address. A full-descending stack therefore pushes with the descending-below mode and pops with the ascending-from-base mode. The surrounding datapath performs the actual memory and register accesses. The block only sequences them, and a sequence cannot be cut short once it has started.

Top module: `blkx_seq_top`

## Requirements
- R1: With N selected registers and aligned base B, the first transfer address is B for mode 0, B+4 for mode 1, B-4N+4 for mode 2 and B-4N for mode 3.
- R2: Base bits [1:0] are treated as zero, and each transfer address is word aligned and 4 above the previous one within a sequence.
- R3: Selected registers are reported in strictly increasing register number, one per transfer, so the lowest selected register gets the lowest address.
- R4: With writeback enabled, `base_o` during the done cycle is B+4N for modes 0 and 1 and B-4N for modes 2 and 3 (modulo 2^32).
- R5: With writeback disabled, `base_o` during the done cycle equals the aligned base B.
- R6: For a start accepted at a clock edge, `busy_o` is high for the following N+2 cycles, and `done_o` is high in the last of them.
- R7: An empty mask produces no transfer, raises `done_o` in the second cycle after the start and returns the base unchanged.
- R8: A start pulse that arrives while `busy_o` is high is ignored and leaves the sequence in progress unaltered.
- R9: `done_o` lasts one cycle, and `busy_o` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Register select mask, bit k selects register k |
| mode_i | input | 2 | Walk mode: 0 up-from-base, 1 up-from-next, 2 down-ending-at-base, 3 down-below-base |
| wb_i | input | 1 | Writeback enable |
| busy_o | output | 1 | Sequence in progress |
| xfer_vld_o | output | 1 | A transfer is presented this cycle |
| xfer_addr_o | output | 32 | Word address of the transfer |
| xfer_reg_o | output | 4 | Register number of the transfer |
| done_o | output | 1 | One-cycle completion pulse |
| base_o | output | 32 | Writeback base value, valid with done_o |

## Verification
The sequence is tried with a contiguous three-register mask in all four modes. Agreement across the modes separates the four start-address formulas and the two writeback directions. Sparse masks (end registers only, alternating bits) and the full mask show whether register order and address stride stay tied to mask position rather than to transfer count. Further cases cover an unaligned base, a base near zero that wraps when descending, an empty mask and a start pulse injected mid-sequence. These expose alignment masking, wrap arithmetic, the zero-transfer path and the guard against restarts.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
    parameter int unsigned ADDR_W     = 32;
    parameter int unsigned NREG       = 16;
    parameter int unsigned WORD_BYTES = 4;
    localparam int unsigned IDX_W     = $clog2(NREG);
    localparam int unsigned CNT_W     = $clog2(NREG + 1);
    localparam int unsigned ALIGN_W   = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        WALK_UP_BASE  = 2'd0,
        WALK_UP_NEXT  = 2'd1,
        WALK_DN_AT    = 2'd2,
        WALK_DN_BELOW = 2'd3
    } walk_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_MOVE = 2'd2,
        ST_FIN  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [NREG-1:0]   sel;
        walk_mode_e        mode;
        logic              wb;
    } xfer_req_t;

    function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        r = a;
        r[ALIGN_W-1:0] = '0;
        return r;
    endfunction

    function automatic logic is_descending(input walk_mode_e m);
        return m[1];
    endfunction
endpackage

// File: rtl/blkx_low_pick.sv
module blkx_low_pick #(
    parameter int unsigned NREG = 16,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  sel_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [NREG-1:0]  low_o
);
    logic [NREG:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NREG; g++) begin : g_scan
        assign low_o[g]    = sel_i[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | sel_i[g];
    end

    assign any_o = seen[NREG];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (low_o[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    always_comb begin
        AST_PICK_ONE: assert ($onehot0(low_o)); // R3
        if (any_o) begin
            AST_PICK_SET: assert (sel_i[idx_o]); // R3
        end
    end
endmodule

// File: rtl/blkx_addr_calc.sv
module blkx_addr_calc
    import blkx_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned NSEL = 16,
    parameter int unsigned STEP = 4,
    localparam int unsigned CW  = $clog2(NSEL + 1)
) (
    input  logic [AW-1:0]   base_i,
    input  logic [NSEL-1:0] sel_i,
    input  walk_mode_e      mode_i,
    output logic [CW-1:0]   cnt_o,
    output logic [AW-1:0]   first_o,
    output logic [AW-1:0]   wb_o
);
    logic [AW-1:0] span;
    logic [AW-1:0] step;

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < NSEL; i++) begin
            cnt_o = cnt_o + CW'(sel_i[i]);
        end
    end

    assign step = AW'(STEP);
    assign span = AW'(cnt_o) * step;

    always_comb begin
        unique case (mode_i)
            WALK_UP_BASE:  first_o = base_i;
            WALK_UP_NEXT:  first_o = base_i + step;
            WALK_DN_AT:    first_o = base_i - span + step;
            default:       first_o = base_i - span;
        endcase
        wb_o = is_descending(mode_i) ? (base_i - span) : (base_i + span);
    end
endmodule

// File: rtl/blkx_seq_top.sv
module blkx_seq_top
    import blkx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] base_i,
    input  logic [15:0] mask_i,
    input  logic [1:0]  mode_i,
    input  logic        wb_i,
    output logic        busy_o,
    output logic        xfer_vld_o,
    output logic [31:0] xfer_addr_o,
    output logic [3:0]  xfer_reg_o,
    output logic        done_o,
    output logic [31:0] base_o
);
    seq_state_e        state_q;
    xfer_req_t         req_q;
    logic [NREG-1:0]   left_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] nbase_q;

    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;
    logic [NREG-1:0]   pick_low;
    logic [NREG-1:0]   left_nxt;
    logic [CNT_W-1:0]  sel_cnt;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] wb_addr;

    blkx_low_pick #(.NREG(NREG)) i_pick (
        .sel_i (left_q),
        .any_o (pick_any),
        .idx_o (pick_idx),
        .low_o (pick_low)
    );

    blkx_addr_calc #(.AW(ADDR_W), .NSEL(NREG), .STEP(WORD_BYTES)) i_calc (
        .base_i  (req_q.base),
        .sel_i   (req_q.sel),
        .mode_i  (req_q.mode),
        .cnt_o   (sel_cnt),
        .first_o (first_addr),
        .wb_o    (wb_addr)
    );

    assign left_nxt = left_q & ~pick_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            left_q  <= '0;
            addr_q  <= '0;
            nbase_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        req_q.base <= align_down(base_i);
                        req_q.sel  <= mask_i;
                        req_q.mode <= walk_mode_e'(mode_i);
                        req_q.wb   <= wb_i;
                        left_q     <= mask_i;
                        state_q    <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    addr_q  <= first_addr;
                    nbase_q <= req_q.wb ? wb_addr : req_q.base;
                    state_q <= (sel_cnt == '0) ? ST_FIN : ST_MOVE;
                end
                ST_MOVE: begin
                    left_q <= left_nxt;
                    addr_q <= addr_q + ADDR_W'(WORD_BYTES);
                    if (left_nxt == '0) state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign xfer_vld_o  = (state_q == ST_MOVE) && pick_any;
    assign xfer_addr_o = addr_q;
    assign xfer_reg_o  = pick_idx;
    assign done_o      = (state_q == ST_FIN);
    assign base_o      = nbase_q;

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o |=> busy_o); // R6
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        xfer_vld_o |-> xfer_addr_o[ALIGN_W-1:0] == '0); // R2
    AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (rst)
        xfer_vld_o && $past(xfer_vld_o) |-> xfer_addr_o == $past(xfer_addr_o) + ADDR_W'(WORD_BYTES)); // R2
    AST_REG_RISING: assert property (@(posedge clk) disable iff (rst)
        xfer_vld_o && $past(xfer_vld_o) |-> xfer_reg_o > $past(xfer_reg_o)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o); // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(req_q)); // R8
    AST_EMPTY_FIN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PREP) && (req_q.sel == '0) |=> done_o && !xfer_vld_o); // R7
endmodule

// File: tb/test_blkx_seq_top.sv
`timescale 1ns/1ps
module test_blkx_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] mask_i = '0;
    logic [1:0]  mode_i = '0;
    logic        wb_i = 1'b0;
    logic        busy_o, xfer_vld_o, done_o;
    logic [31:0] xfer_addr_o, base_o;
    logic [3:0]  xfer_reg_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_done;
        logic [31:0] val;
        logic [3:0]  rg;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    blkx_seq_top i_blkx_seq_top (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i),
        .mask_i(mask_i), .mode_i(mode_i), .wb_i(wb_i), .busy_o(busy_o),
        .xfer_vld_o(xfer_vld_o), .xfer_addr_o(xfer_addr_o),
        .xfer_reg_o(xfer_reg_o), .done_o(done_o), .base_o(base_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as the design produces results
    always @(negedge clk) begin
        if (!rst && (xfer_vld_o || done_o)) begin
            if (sb.size() == 0) begin
                chk("R7 unexpected output", {30'd0, xfer_vld_o, done_o}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_done) begin
                    chk({e.tag, " done kind"}, {31'd0, done_o}, 32'd1);
                    chk({e.tag, " base"}, base_o, e.val);
                end else begin
                    chk({e.tag, " xfer kind"}, {31'd0, xfer_vld_o}, 32'd1);
                    chk({e.tag, " addr"}, xfer_addr_o, e.val);
                    chk("R3 reg", {28'd0, xfer_reg_o}, {28'd0, e.rg});
                end
            end
        end
    end

    task automatic run_op(input logic [31:0] b, input logic [15:0] m,
                          input logic [1:0] md, input logic wb, input bit poke);
        logic [31:0] ab, span, a, nb;
        int n, k;
        exp_t e;
        ab = {b[31:2], 2'b00};
        n = $countones(m);
        span = 32'(n) * 32'd4;
        case (md)
            2'd0: a = ab;
            2'd1: a = ab + 32'd4;
            2'd2: a = ab - span + 32'd4;
            default: a = ab - span;
        endcase
        nb = !wb ? ab : (md[1] ? ab - span : ab + span);
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                e.is_done = 1'b0; e.val = a; e.rg = 4'(i);
                e.tag = (a == ((md == 2'd0) ? ab : (md == 2'd1) ? ab + 32'd4 :
                        (md == 2'd2) ? ab - span + 32'd4 : ab - span)) ? "R1" : "R2";
                sb.push_back(e);
                a = a + 32'd4;
            end
        end
        e.is_done = 1'b1; e.val = nb; e.rg = '0;
        e.tag = (n == 0) ? "R7" : (wb ? "R4" : "R5");
        sb.push_back(e);

        @(negedge clk);
        base_i = b; mask_i = m; mode_i = md; wb_i = wb; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 1;
        while (k < 40) begin
            chk("R6 busy during sequence", {31'd0, busy_o}, 32'd1);
            if (done_o) break;
            if (poke && k == 2) begin
                start_i = 1'b1; base_i = 32'hDEAD_BEE0; mask_i = 16'hFFFF;
                mode_i = 2'd3; wb_i = ~wb;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start_i = 1'b0;
        chk(n == 0 ? "R7 done cycle" : "R6 done cycle", 32'(k), 32'(n + 2));
        @(negedge clk);
        chk("R9 idle after done", {30'd0, busy_o, done_o}, 32'd0);
        chk("R8 queue drained", 32'(sb.size()), 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R6 watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset state", {29'd0, busy_o, xfer_vld_o, done_o}, 32'd0);

        run_op(32'h0000_0010, 16'h000E, 2'd0, 1'b1, 1'b0); // R1 R4 up-from-base
        run_op(32'h0000_0024, 16'h000E, 2'd2, 1'b1, 1'b0); // R1 R4 down-at-base
        run_op(32'h0000_0100, 16'h000E, 2'd1, 1'b1, 1'b0); // R1 up-from-next
        run_op(32'h0000_0100, 16'h000E, 2'd3, 1'b1, 1'b0); // R1 down-below
        run_op(32'h0000_2000, 16'h8001, 2'd0, 1'b0, 1'b0); // R3 R5 sparse
        run_op(32'h0000_2000, 16'h5555, 2'd2, 1'b0, 1'b0); // R3 R5
        run_op(32'h0000_4000, 16'hFFFF, 2'd3, 1'b1, 1'b0); // R3 R4 full mask
        run_op(32'h0000_0013, 16'h0030, 2'd1, 1'b1, 1'b0); // R2 unaligned base
        run_op(32'h0000_0008, 16'h00F0, 2'd3, 1'b1, 1'b0); // R4 wrap below zero
        run_op(32'h0000_0400, 16'h0000, 2'd2, 1'b1, 1'b0); // R7 empty mask
        run_op(32'h0000_0800, 16'h0C06, 2'd0, 1'b1, 1'b1); // R8 start while busy
        run_op(32'h0000_0800, 16'h0300, 2'd2, 1'b0, 1'b1); // R8 R5

        repeat (3) @(negedge clk);
        chk("R8 no extra outputs", {30'd0, xfer_vld_o, done_o}, 32'd0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule